// File: doc/BRIEF.md
# Graphics Function Base Address Registers and Cycle Claim Decoder

This block keeps two base address registers for a graphics function. One places a 512 KB window in 32-bit memory space. The other places an 8-byte window in 16-bit I/O space. Each register has a writable base field and constant low bits. Software finds the window size by writing all-ones to a register and reading back which bits stayed set.

Configuration software programs the registers through a plain dword-indexed port. That port has a function number, write data, byte enables and a combinational read path. Only function 0 carries the registers.

On the CPU side, the block compares each incoming memory or I/O cycle against the programmed windows. It raises a claim in the same cycle as the request. A memory claim needs only the memory-space enable. An I/O claim also needs all of the following:
- the function is in full-power state D0;
- the I/O enable is set;
- the device is not switched off;
- integrated graphics is not disabled.

Top module: `gbar_decode_top`

## Requirements
- R1: After a synchronous active-low reset, the memory register reads 0x00000000 and the I/O register reads 0x00000001.
- R2: The memory register stores only bits [31:19]. Bits [18:0] always read 0, so writing 0xFFFFFFFF to it reads back 0xFFF80000.
- R3: The I/O register stores only bits [15:3]. Bits [31:16] and [2:1] always read 0 and bit 0 always reads 1, so writing 0xFFFFFFFF to it reads back 0x0000FFF9.
- R4: A configuration write changes only the stored bits whose byte lane has its enable set. Byte enable bit k covers data bits [8k+7:8k].
- R5: The registers are reached at dword index 5 (memory) and 6 (I/O), and only with function number 0. With any other function, or at any other index, reads return 0 and writes change nothing.
- R6: The read data follows the current index and function without a clock. A write is visible from the clock edge that accepts it.
- R7: `claim_mem` is high exactly when `req_valid` is high, `req_io` is low, `mem_en` is high and address bits [31:19] equal the stored memory base.
- R8: `claim_io` is high exactly when all of the following hold:
  - `req_valid` is high and `req_io` is high;
  - address bits [31:16] are 0 and address bits [15:3] equal the stored I/O base;
  - the gating of R9 permits it.
  
  The cycle width plays no part, so any byte inside the window is claimed.
- R9: I/O claims need `pwr_state` = 0 (D0; values 1 to 3 are D1 to D3), `io_en` = 1, `dev_off` = 0 and `gfx_dis` = 0. These four inputs do not affect `claim_mem`.
- R10: `claim` is the OR of `claim_mem` and `claim_io`. All three outputs are combinational and valid in the request cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_func | input | 3 | Function number of the configuration access |
| cfg_dw | input | 6 | Dword index of the configuration access |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_rdata | output | 32 | Configuration read data |
| req_valid | input | 1 | CPU cycle present |
| req_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| req_addr | input | 32 | CPU cycle address |
| mem_en | input | 1 | Memory-space enable from command register |
| io_en | input | 1 | I/O enable from command register |
| pwr_state | input | 2 | Power state, 0 = D0 up to 3 = D3 |
| dev_off | input | 1 | Device switched off |
| gfx_dis | input | 1 | Integrated graphics disabled |
| claim_mem | output | 1 | Memory window hit |
| claim_io | output | 1 | I/O window hit |
| claim | output | 1 | Either window hit |

## Verification
The bench builds the block with its default parameters: a 2^19-byte memory window, a 2^3-byte I/O window, and the registers at dword indices 5 and 6. With these values both writable fields start in the middle of a byte lane (bit 19 in lane 2, bit 3 in lane 0). Random byte-enable patterns therefore exercise split-lane merges on both registers. Addresses are aimed at the live bases half of the time, so hits, near misses and nonzero upper I/O bits all occur under every combination of the four I/O gating inputs.

// File: rtl/gbar_pkg.sv
// Package: shared widths and the power-state encoding for the BAR decoder.
// Assumes a 32-bit configuration data path and dword-indexed config space.
package gbar_pkg;
    localparam int CFG_DW_W   = 6;
    localparam int CFG_FUNC_W = 3;
    localparam int DATA_W     = 32;
    localparam int IO_SPACE_W = 16;

    typedef enum logic [1:0] {
        PS_D0 = 2'd0,
        PS_D1 = 2'd1,
        PS_D2 = 2'd2,
        PS_D3 = 2'd3
    } pwr_state_e;
endpackage

// File: rtl/gbar_base_reg.sv
// Module: one base address register with a writable field [HI:LO] and
// constant bits elsewhere. Writes merge per byte lane.
// Assumes: HI >= LO, HI < DATA_W; FIXED holds the constant read value of
// all non-field bits (its field bits are ignored).
module gbar_base_reg
    import gbar_pkg::*;
#(
    parameter int              LO    = 19,
    parameter int              HI    = 31,
    parameter logic [DATA_W-1:0] FIXED = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W/8-1:0] be,
    output logic [HI-LO:0]    base_q,
    output logic [DATA_W-1:0] rd_val
);
    localparam int FW = HI - LO + 1;

    logic [FW-1:0] base_d;

    // Per-bit merge: take write data only where the bit's byte lane is enabled.
    for (genvar i = 0; i < FW; i++) begin : g_bit
        assign base_d[i] = be[(i + LO) / 8] ? wdata[i + LO] : base_q[i];
    end

    // Base field storage, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_en) begin
            base_q <= base_d;
        end
    end

    // Read value: constant bits with the stored field overlaid.
    always_comb begin
        rd_val = FIXED;
        for (int k = 0; k < FW; k++) begin
            rd_val[k + LO] = base_q[k];
        end
    end

    // R4: without a write strobe the field keeps its value.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> base_q == $past(base_q));

    // R4: a write with no byte lane enabled leaves the field unchanged.
    p_no_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && be == '0) |=> $stable(base_q));
endmodule

// File: rtl/gbar_claim_decode.sv
// Module: compares a CPU cycle against both windows and applies the
// enable and power gating. Purely combinational outputs.
// Assumes: I/O space is IO_SPACE_W bits wide; higher address bits must be 0.
module gbar_claim_decode
    import gbar_pkg::*;
#(
    parameter int MEM_LO = 19,
    parameter int IO_LO  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_io,
    input  logic [DATA_W-1:0]             req_addr,
    input  logic [DATA_W-1-MEM_LO:0]      mem_base,
    input  logic [IO_SPACE_W-1-IO_LO:0]   io_base,
    input  logic                          mem_en,
    input  logic                          io_en,
    input  pwr_state_e                    pwr_state,
    input  logic                          dev_off,
    input  logic                          gfx_dis,
    output logic                          claim_mem,
    output logic                          claim_io
);
    logic mem_hit;
    logic io_hit;
    logic io_allowed;

    // Window compares on the upper address bits only.
    always_comb begin
        mem_hit = req_addr[DATA_W-1:MEM_LO] == mem_base;
        io_hit  = (req_addr[DATA_W-1:IO_SPACE_W] == '0) &&
                  (req_addr[IO_SPACE_W-1:IO_LO] == io_base);
    end

    // I/O gating: full power, enabled, device on, graphics present.
    assign io_allowed = (pwr_state == PS_D0) && io_en && !dev_off && !gfx_dis;

    // Final claims per space.
    always_comb begin
        claim_mem = req_valid && !req_io && mem_en && mem_hit;
        claim_io  = req_valid && req_io && io_allowed && io_hit;
    end

    // R9: an I/O claim never appears outside D0 or with a blocking input.
    p_io_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        claim_io |-> (pwr_state == PS_D0 && io_en && !dev_off && !gfx_dis));

    // R8: an I/O claim only for addresses inside 16-bit I/O space.
    p_io_space_r8: assert property (@(posedge clk) disable iff (!rst_n)
        claim_io |-> req_addr[DATA_W-1:IO_SPACE_W] == '0);

    // R10: a single cycle can never hit both spaces.
    p_one_space_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(claim_io && claim_mem));

    // R7: a memory claim requires memory-space enable and a memory cycle.
    p_mem_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        claim_mem |-> (mem_en && !req_io && req_valid));
endmodule

// File: rtl/gbar_decode_top.sv
// Module: top of the graphics BAR block. Holds the memory and I/O base
// registers, serves configuration reads/writes for function 0, and claims
// matching CPU cycles.
// Assumes: cfg_rdata is sampled by the requester combinationally; writes
// are single-cycle strobes.
module gbar_decode_top
    import gbar_pkg::*;
#(
    parameter int                 MEM_WIN_LOG2 = 19,
    parameter int                 IO_WIN_LOG2  = 3,
    parameter logic [CFG_DW_W-1:0] MEM_BAR_DW  = 6'd5,
    parameter logic [CFG_DW_W-1:0] IO_BAR_DW   = 6'd6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [CFG_FUNC_W-1:0] cfg_func,
    input  logic [CFG_DW_W-1:0]   cfg_dw,
    input  logic [DATA_W-1:0]     cfg_wdata,
    input  logic [DATA_W/8-1:0]   cfg_be,
    output logic [DATA_W-1:0]     cfg_rdata,
    input  logic                  req_valid,
    input  logic                  req_io,
    input  logic [DATA_W-1:0]     req_addr,
    input  logic                  mem_en,
    input  logic                  io_en,
    input  logic [1:0]            pwr_state,
    input  logic                  dev_off,
    input  logic                  gfx_dis,
    output logic                  claim_mem,
    output logic                  claim_io,
    output logic                  claim
);
    localparam int MEM_FW = DATA_W - MEM_WIN_LOG2;
    localparam int IO_FW  = IO_SPACE_W - IO_WIN_LOG2;
    localparam logic [DATA_W-1:0] IO_FIXED = 32'h0000_0001;

    logic              func0;
    logic              sel_mem;
    logic              sel_io;
    logic [MEM_FW-1:0] mem_base;
    logic [IO_FW-1:0]  io_base;
    logic [DATA_W-1:0] mem_rd;
    logic [DATA_W-1:0] io_rd;

    // Register select: only function 0 owns the BARs.
    always_comb begin
        func0   = cfg_func == '0;
        sel_mem = func0 && cfg_dw == MEM_BAR_DW;
        sel_io  = func0 && cfg_dw == IO_BAR_DW;
    end

    gbar_base_reg #(
        .LO    (MEM_WIN_LOG2),
        .HI    (DATA_W - 1),
        .FIXED ('0)
    ) u_mem_bar (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr && sel_mem),
        .wdata  (cfg_wdata),
        .be     (cfg_be),
        .base_q (mem_base),
        .rd_val (mem_rd)
    );

    gbar_base_reg #(
        .LO    (IO_WIN_LOG2),
        .HI    (IO_SPACE_W - 1),
        .FIXED (IO_FIXED)
    ) u_io_bar (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr && sel_io),
        .wdata  (cfg_wdata),
        .be     (cfg_be),
        .base_q (io_base),
        .rd_val (io_rd)
    );

    // Read mux: unselected or foreign-function reads return zero.
    always_comb begin
        if (sel_mem)     cfg_rdata = mem_rd;
        else if (sel_io) cfg_rdata = io_rd;
        else             cfg_rdata = '0;
    end

    gbar_claim_decode #(
        .MEM_LO (MEM_WIN_LOG2),
        .IO_LO  (IO_WIN_LOG2)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_io    (req_io),
        .req_addr  (req_addr),
        .mem_base  (mem_base),
        .io_base   (io_base),
        .mem_en    (mem_en),
        .io_en     (io_en),
        .pwr_state (pwr_state_e'(pwr_state)),
        .dev_off   (dev_off),
        .gfx_dis   (gfx_dis),
        .claim_mem (claim_mem),
        .claim_io  (claim_io)
    );

    // Combined claim for the upstream arbiter.
    assign claim = claim_mem || claim_io;

    // R5: writes aimed at a non-zero function never alter either base.
    p_func_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_func != '0) |=> (mem_base == $past(mem_base) && io_base == $past(io_base)));

    // R3: I/O register bit 0 reads one whenever it is selected.
    p_io_bit0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_io |-> cfg_rdata[0] == 1'b1);
endmodule

// File: tb/tb_gbar_decode_top.sv
module tb_gbar_decode_top;
    localparam int N_RAND = 4000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [2:0]  cfg_func;
    logic [5:0]  cfg_dw;
    logic [31:0] cfg_wdata;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_rdata;
    logic        req_valid, req_io;
    logic [31:0] req_addr;
    logic        mem_en, io_en;
    logic [1:0]  pwr_state;
    logic        dev_off, gfx_dis;
    logic        claim_mem, claim_io, claim;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // Bench model of the stored fields.
    logic [12:0] m_base;
    logic [12:0] i_base;

    gbar_decode_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_func(cfg_func),
        .cfg_dw(cfg_dw), .cfg_wdata(cfg_wdata), .cfg_be(cfg_be),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_io(req_io),
        .req_addr(req_addr), .mem_en(mem_en), .io_en(io_en),
        .pwr_state(pwr_state), .dev_off(dev_off), .gfx_dis(gfx_dis),
        .claim_mem(claim_mem), .claim_io(claim_io), .claim(claim)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] exp_rd(input logic [2:0] f, input logic [5:0] dw);
        if (f != 0)       return 32'h0;
        if (dw == 6'd5)   return {m_base, 19'h0};
        if (dw == 6'd6)   return {16'h0, i_base, 3'b001};
        return 32'h0;
    endfunction

    function automatic logic exp_mem();
        return req_valid && !req_io && mem_en && (req_addr[31:19] == m_base);
    endfunction

    function automatic logic exp_io();
        return req_valid && req_io && io_en && pwr_state == 2'd0 && !dev_off &&
               !gfx_dis && req_addr[31:16] == 16'h0 && req_addr[15:3] == i_base;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                          input logic [3:0] be);
        logic [31:0] r;
        for (int k = 0; k < 32; k++) r[k] = be[k/8] ? d[k] : old[k];
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, expv);
        end
    endtask

    // Checks all outputs against the model; called after inputs settle.
    task automatic check_all(input string tag);
        logic [31:0] e;
        e = exp_rd(cfg_func, cfg_dw);
        check(cfg_rdata === e, {tag, " R5/R6 rdata"}, cfg_rdata, e);
        check(claim_mem === exp_mem(), {tag, " R7 claim_mem"}, 32'(claim_mem), 32'(exp_mem()));
        check(claim_io === exp_io(), {tag, " R8/R9 claim_io"}, 32'(claim_io), 32'(exp_io()));
        check(claim === (exp_mem() | exp_io()), {tag, " R10 claim"}, 32'(claim),
              32'(exp_mem() | exp_io()));
    endtask

    // One cycle: apply at negedge, check comb outputs, then commit on posedge.
    task automatic step(input string tag);
        logic [31:0] nm, ni;
        #1;
        check_all(tag);
        nm = {m_base, 19'h0};
        ni = {16'h0, i_base, 3'b0};
        if (rst_n && cfg_wr && cfg_func == 0 && cfg_dw == 6'd5) nm = merge(nm, cfg_wdata, cfg_be);
        if (rst_n && cfg_wr && cfg_func == 0 && cfg_dw == 6'd6) ni = merge(ni, cfg_wdata, cfg_be);
        @(posedge clk);
        m_base = nm[31:19];
        i_base = ni[15:3];
        @(negedge clk);
    endtask

    task automatic idle();
        cfg_wr = 0; cfg_func = 0; cfg_dw = 0; cfg_wdata = 0; cfg_be = 0;
        req_valid = 0; req_io = 0; req_addr = 0;
        mem_en = 1; io_en = 1; pwr_state = 0; dev_off = 0; gfx_dis = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0BA5_E0F1));
        idle();
        rst_n = 0;
        m_base = 0;
        i_base = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset values.
        cfg_dw = 6'd5; #1;
        check(cfg_rdata === 32'h0, "R1 mem reset", cfg_rdata, 32'h0);
        cfg_dw = 6'd6; #1;
        check(cfg_rdata === 32'h1, "R1 io reset", cfg_rdata, 32'h1);
        @(negedge clk);

        // R2: all-ones sizing on the memory register.
        cfg_wr = 1; cfg_dw = 6'd5; cfg_wdata = '1; cfg_be = 4'hF;
        step("R2 write");
        cfg_wr = 0; #1;
        check(cfg_rdata === 32'hFFF8_0000, "R2 mem size mask", cfg_rdata, 32'hFFF8_0000);
        // R3: all-ones sizing on the I/O register.
        cfg_wr = 1; cfg_dw = 6'd6;
        step("R3 write");
        cfg_wr = 0; #1;
        check(cfg_rdata === 32'h0000_FFF9, "R3 io size mask", cfg_rdata, 32'h0000_FFF9);

        // R4: clear only lane 3 of memory, lane 0 of I/O.
        cfg_wr = 1; cfg_dw = 6'd5; cfg_wdata = 0; cfg_be = 4'b1000;
        step("R4 lane3");
        cfg_dw = 6'd6; cfg_be = 4'b0001;
        step("R4 lane0");
        cfg_wr = 0; cfg_dw = 6'd5; #1;
        check(cfg_rdata === 32'h00F8_0000, "R4 mem lane merge", cfg_rdata, 32'h00F8_0000);
        cfg_dw = 6'd6; #1;
        check(cfg_rdata === 32'h0000_FF01, "R4 io lane merge", cfg_rdata, 32'h0000_FF01);

        // R5: function 1 write is ignored and reads zero.
        cfg_wr = 1; cfg_func = 3'd1; cfg_dw = 6'd6; cfg_wdata = 32'h1234_5678; cfg_be = 4'hF;
        step("R5 func1");
        cfg_wr = 0; #1;
        check(cfg_rdata === 32'h0, "R5 func1 read", cfg_rdata, 32'h0);
        cfg_func = 0; #1;
        check(cfg_rdata === 32'h0000_FF01, "R5 io untouched", cfg_rdata, 32'h0000_FF01);

        // R8/R9: directed I/O hit at window top byte, then each gate.
        req_valid = 1; req_io = 1; req_addr = {16'h0, i_base, 3'b111}; #1;
        check(claim_io === 1'b1, "R8 io hit top byte", 32'(claim_io), 32'h1);
        dev_off = 1; #1;
        check(claim_io === 1'b0, "R9 dev_off blocks", 32'(claim_io), 32'h0);
        dev_off = 0; pwr_state = 2'd3; #1;
        check(claim_io === 1'b0, "R9 D3 blocks", 32'(claim_io), 32'h0);
        pwr_state = 0; req_io = 0; req_addr = {m_base, 19'h7FFFF}; gfx_dis = 1; io_en = 0; #1;
        check(claim_mem === 1'b1, "R9 gates leave mem claim", 32'(claim_mem), 32'h1);
        idle();
        @(negedge clk);

        // Random mix.
        for (int n = 0; n < N_RAND; n++) begin
            logic [31:0] r;
            r = $urandom;
            cfg_wr    = r[0];
            cfg_func  = (r[3:2] == 0) ? 3'($urandom) : 3'd0;
            cfg_dw    = r[4] ? (r[5] ? 6'd5 : 6'd6) : 6'($urandom);
            cfg_wdata = $urandom;
            cfg_be    = 4'($urandom);
            req_valid = r[6] | r[7];
            req_io    = r[8];
            case (r[10:9])
                2'd0: req_addr = {m_base, 19'($urandom)};
                2'd1: req_addr = {(r[11] ? 16'h0 : 16'($urandom)), i_base, 3'($urandom)};
                default: req_addr = $urandom;
            endcase
            mem_en    = r[12] | r[13];
            io_en     = r[14] | r[15];
            pwr_state = r[16] ? 2'd0 : 2'($urandom);
            dev_off   = (r[19:17] == 0);
            gfx_dis   = (r[22:20] == 0);
            step("rand");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule